// File: doc/BRIEF.md
# Luminance Special Effects Unit

This unit sits in a camera video path. It applies picture effects to an 8-bit luminance stream and to the colour-difference stream that travels with it. Pixels arrive with a valid strobe. A start-of-line marker is raised on the first valid pixel of every line. A start-of-frame marker is raised on the first valid pixel of every frame, and that pixel also carries the line marker. Horizontal and vertical pixel positions are counted from these markers, and only valid pixels advance them.

Five effects are available, each with its own enable input:

- **Mosaic:** block replication, using a small row buffer for the vertical repeat.
- **Slice:** a binary threshold with selectable sense.
- **Solarization:** keeps only a chosen number of low-order bits.
- **Negative:** inversion of luminance.
- **Sepia:** replaces the colour-difference samples with fixed tint values.

The effects are applied in a fixed order: mosaic first, then slice or solarization, then negative, then sepia. Every output appears exactly two clocks after its input, whatever effects are enabled. The control inputs are expected to be held steady while a frame is streaming.

Top module: `luma_fx_unit`

## Requirements
- R1: While rst_ni is low, and on the first sample after reset, vld_o, line_start_o, frame_start_o, uv_sel_o, y_o and c_o are all 0.
- R2: vld_o, line_start_o, frame_start_o, uv_sel_o, y_o and c_o follow the matching inputs exactly 2 clocks later. With every effect disabled, y_o and c_o equal y_i and c_i.
- R3: mos_size_i selects the mosaic block edge: 00 gives 4 pixels, 01 gives 8, 10 gives 16 and 11 gives 32. Blocks are aligned to pixel 0 of the line and line 0 of the frame.
- R4: With mos_en_i set, each output luminance equals the input luminance at the top-left pixel of its block, including on the block's lower lines. Mosaic does not change c_o.
- R5: With slc_en_i set, the luminance becomes either 255 or 0, depending on whether it is greater than or equal to slc_thr_i.
- R6: slc_pol_i=1 (positive sense) gives 255 when the luminance is at or above the threshold and 0 below it. slc_pol_i=0 (negative sense) gives the reverse.
- R7: With sol_en_i set, code sol_keep_i=n keeps the 3+n least-significant luminance bits and shifts them left by 5-n, so the low 5-n bits become 0.
- R8: When slc_en_i and sol_en_i are both set, slice applies and solarization is ignored.
- R9: With neg_en_i set, the luminance after the slice or solarization step is replaced by 255 minus that value.
- R10: With sepia_en_i set, c_o is 8'hF0 (U = -16) for samples with uv_sel_i=0 and 8'h14 (V = +20) for samples with uv_sel_i=1, and luminance is unchanged by sepia.
- R11: Cycles with vld_i low do not advance the pixel position, so mosaic blocks stay aligned across gaps in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Input pixel valid |
| line_start_i | input | 1 | First valid pixel of a line |
| frame_start_i | input | 1 | First valid pixel of a frame |
| uv_sel_i | input | 1 | Colour-difference phase: 0 = U sample, 1 = V sample |
| y_i | input | 8 | Input luminance |
| c_i | input | 8 | Input colour difference, two's complement |
| mos_en_i | input | 1 | Mosaic enable |
| mos_size_i | input | 2 | Mosaic block size code |
| slc_en_i | input | 1 | Slice enable |
| slc_pol_i | input | 1 | Slice sense: 1 = positive, 0 = negative |
| slc_thr_i | input | 8 | Slice threshold |
| sol_en_i | input | 1 | Solarization enable |
| sol_keep_i | input | 2 | Solarization bit-count code (keeps 3 to 6 bits) |
| neg_en_i | input | 1 | Negative inversion enable |
| sepia_en_i | input | 1 | Sepia enable |
| vld_o | output | 1 | Output pixel valid |
| line_start_o | output | 1 | Delayed line marker |
| frame_start_o | output | 1 | Delayed frame marker |
| uv_sel_o | output | 1 | Delayed colour-difference phase |
| y_o | output | 8 | Processed luminance |
| c_o | output | 8 | Processed colour difference |

## Verification
A horizontal position counter that slips, for example one that advances on an idle cycle, shows up as mosaic steps on the wrong pixel. That error appears on the first block boundary after the slip, within one block width of output. A wrong entry in the row buffer is invisible on the top line of a block and appears only on the following line of that block. A latency error or a wrong sepia value shows at once on the first valid output sample.

// File: rtl/luma_fx_pkg.sv
package luma_fx_pkg;
  localparam int unsigned PIX_W = 8;
  localparam logic [PIX_W-1:0] SEPIA_U = 8'hF0;  // -16
  localparam logic [PIX_W-1:0] SEPIA_V = 8'h14;  // +20

  // position mask inside a mosaic block (edge 4/8/16/32)
  function automatic logic [4:0] blk_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 5'd3;
      2'b01:   return 5'd7;
      2'b10:   return 5'd15;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/luma_fx_mosaic.sv
module luma_fx_mosaic
  import luma_fx_pkg::*;
#(
  parameter int unsigned MAX_LINE = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             line_start_i,
  input  logic             frame_start_i,
  input  logic             uv_sel_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] c_i,
  input  logic             mos_en_i,
  input  logic [1:0]       mos_size_i,
  output logic             vld_o,
  output logic             line_start_o,
  output logic             frame_start_o,
  output logic             uv_sel_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] c_o
);
  localparam int unsigned XW    = $clog2(MAX_LINE);
  localparam int unsigned BW    = XW - 2;
  localparam int unsigned DEPTH = MAX_LINE / 4;

  logic [XW-1:0]    x_q, x_cur;
  logic [4:0]       ln_q, ln_cur;
  logic [4:0]       mask;
  logic             blk_head, top_row;
  logic [2:0]       sh;
  logic [BW-1:0]    bidx;
  logic [PIX_W-1:0] hold_q, mos_val;
  logic [PIX_W-1:0] row_mem [DEPTH];

  always_comb begin
    x_cur = line_start_i ? '0 : x_q;
    if (frame_start_i)     ln_cur = '0;
    else if (line_start_i) ln_cur = ln_q + 5'd1;
    else                   ln_cur = ln_q;
  end

  assign mask     = blk_mask(mos_size_i);
  assign blk_head = (x_cur[4:0] & mask) == 5'd0;
  assign top_row  = (ln_cur & mask) == 5'd0;
  assign sh       = {1'b0, mos_size_i} + 3'd2;
  assign bidx     = BW'(x_cur >> sh);

  always_comb begin
    if (top_row) mos_val = blk_head ? y_i : hold_q;
    else         mos_val = row_mem[bidx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      ln_q   <= '0;
      hold_q <= '0;
    end else if (vld_i) begin
      x_q    <= x_cur + XW'(1);
      ln_q   <= ln_cur;
      hold_q <= mos_val;
    end
  end

  // one entry per block column, written on the block's top line
  always_ff @(posedge clk_i) begin
    if (vld_i && top_row && blk_head) row_mem[bidx] <= y_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o         <= 1'b0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
      uv_sel_o      <= 1'b0;
      y_o           <= '0;
      c_o           <= '0;
    end else begin
      vld_o         <= vld_i;
      line_start_o  <= vld_i & line_start_i;
      frame_start_o <= vld_i & frame_start_i;
      uv_sel_o      <= uv_sel_i;
      y_o           <= mos_en_i ? mos_val : y_i;
      c_o           <= c_i;
    end
  end

  AST_MOS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && $past(vld_i) && mos_en_i && !line_start_i && !blk_head) |=> $stable(y_o))
    else $error("mosaic sample changed inside a block");  // R4
endmodule

// File: rtl/luma_fx_tone.sv
module luma_fx_tone
  import luma_fx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             line_start_i,
  input  logic             frame_start_i,
  input  logic             uv_sel_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] c_i,
  input  logic             slc_en_i,
  input  logic             slc_pol_i,
  input  logic [PIX_W-1:0] slc_thr_i,
  input  logic             sol_en_i,
  input  logic [1:0]       sol_keep_i,
  input  logic             neg_en_i,
  input  logic             sepia_en_i,
  output logic             vld_o,
  output logic             line_start_o,
  output logic             frame_start_o,
  output logic             uv_sel_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] c_o
);
  logic [2:0]       sol_sh;
  logic [PIX_W-1:0] slc_val, sol_val, pt_val, y_nxt, c_nxt;

  assign sol_sh  = 3'd5 - {1'b0, sol_keep_i};
  assign slc_val = ((y_i >= slc_thr_i) == slc_pol_i) ? 8'hFF : 8'h00;
  assign sol_val = y_i << sol_sh;  // upper bits fall off, low bits zero

  always_comb begin
    if (slc_en_i)      pt_val = slc_val;
    else if (sol_en_i) pt_val = sol_val;
    else               pt_val = y_i;
    y_nxt = neg_en_i ? (8'hFF - pt_val) : pt_val;
    if (sepia_en_i) c_nxt = uv_sel_i ? SEPIA_V : SEPIA_U;
    else            c_nxt = c_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o         <= 1'b0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
      uv_sel_o      <= 1'b0;
      y_o           <= '0;
      c_o           <= '0;
    end else begin
      vld_o         <= vld_i;
      line_start_o  <= line_start_i;
      frame_start_o <= frame_start_i;
      uv_sel_o      <= uv_sel_i;
      y_o           <= y_nxt;
      c_o           <= c_nxt;
    end
  end

  AST_SLICE_BINARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slc_en_i && !neg_en_i) |-> (y_o == 8'h00 || y_o == 8'hFF))
    else $error("slice output not binary");  // R5

  AST_SOL_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sol_en_i && !slc_en_i && !neg_en_i) |-> (y_o[1:0] == 2'b00))
    else $error("solarized low bits not cleared");  // R7

  AST_SEPIA_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sepia_en_i) |-> (c_o == ($past(uv_sel_i) ? SEPIA_V : SEPIA_U)))
    else $error("sepia chroma wrong");  // R10
endmodule

// File: rtl/luma_fx_unit.sv
module luma_fx_unit
  import luma_fx_pkg::*;
#(
  parameter int unsigned MAX_LINE = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic       line_start_i,
  input  logic       frame_start_i,
  input  logic       uv_sel_i,
  input  logic [7:0] y_i,
  input  logic [7:0] c_i,
  input  logic       mos_en_i,
  input  logic [1:0] mos_size_i,
  input  logic       slc_en_i,
  input  logic       slc_pol_i,
  input  logic [7:0] slc_thr_i,
  input  logic       sol_en_i,
  input  logic [1:0] sol_keep_i,
  input  logic       neg_en_i,
  input  logic       sepia_en_i,
  output logic       vld_o,
  output logic       line_start_o,
  output logic       frame_start_o,
  output logic       uv_sel_o,
  output logic [7:0] y_o,
  output logic [7:0] c_o
);
  logic             s1_vld, s1_ls, s1_fs, s1_uv;
  logic [PIX_W-1:0] s1_y, s1_c;

  luma_fx_mosaic #(.MAX_LINE(MAX_LINE)) u_mosaic (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vld_i         (vld_i),
    .line_start_i  (line_start_i),
    .frame_start_i (frame_start_i),
    .uv_sel_i      (uv_sel_i),
    .y_i           (y_i),
    .c_i           (c_i),
    .mos_en_i      (mos_en_i),
    .mos_size_i    (mos_size_i),
    .vld_o         (s1_vld),
    .line_start_o  (s1_ls),
    .frame_start_o (s1_fs),
    .uv_sel_o      (s1_uv),
    .y_o           (s1_y),
    .c_o           (s1_c)
  );

  luma_fx_tone u_tone (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vld_i         (s1_vld),
    .line_start_i  (s1_ls),
    .frame_start_i (s1_fs),
    .uv_sel_i      (s1_uv),
    .y_i           (s1_y),
    .c_i           (s1_c),
    .slc_en_i      (slc_en_i),
    .slc_pol_i     (slc_pol_i),
    .slc_thr_i     (slc_thr_i),
    .sol_en_i      (sol_en_i),
    .sol_keep_i    (sol_keep_i),
    .neg_en_i      (neg_en_i),
    .sepia_en_i    (sepia_en_i),
    .vld_o         (vld_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o),
    .uv_sel_o      (uv_sel_o),
    .y_o           (y_o),
    .c_o           (c_o)
  );

  // edges seen since reset, saturating; gates the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (vld_o == $past(vld_i, 2)))
    else $error("valid latency not 2");  // R2
endmodule

// File: tb/luma_fx_unit_bench.sv
module luma_fx_unit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAXN       = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 0, ls = 0, fs = 0, uv = 0;
  logic [7:0] y = 0, c = 0;
  logic c_mos = 0, c_slc = 0, c_pol = 0, c_sol = 0, c_neg = 0, c_sep = 0;
  logic [1:0] c_size = 0, c_keep = 0;
  logic [7:0] c_thr = 0;
  logic vld_o, ls_o, fs_o, uv_o;
  logic [7:0] y_o, c_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  luma_fx_unit u_luma_fx_unit (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .line_start_i(ls), .frame_start_i(fs),
    .uv_sel_i(uv), .y_i(y), .c_i(c),
    .mos_en_i(c_mos), .mos_size_i(c_size), .slc_en_i(c_slc), .slc_pol_i(c_pol),
    .slc_thr_i(c_thr), .sol_en_i(c_sol), .sol_keep_i(c_keep), .neg_en_i(c_neg),
    .sepia_en_i(c_sep), .vld_o(vld_o), .line_start_o(ls_o), .frame_start_o(fs_o),
    .uv_sel_o(uv_o), .y_o(y_o), .c_o(c_o)
  );

  int checks = 0, errors = 0;
  int exp_y[MAXN], exp_c[MAXN], exp_uv[MAXN], exp_ls[MAXN], exp_fs[MAXN];
  int exp_n = 0, out_idx = 0;
  bit mon_en = 0;
  string cur_req = "R2";

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int pix(input int x, input int ln, input int seed);
    return (x*7 + ln*13 + seed*29) % 256;
  endfunction

  function automatic int model_y(input int x, input int ln, input int seed);
    int b = 4 << c_size;
    int m, k;
    m = c_mos ? pix(x - (x % b), ln - (ln % b), seed) : pix(x, ln, seed);
    if (c_slc) m = (((m >= int'(c_thr)) ? 1 : 0) == int'(c_pol)) ? 255 : 0;
    else if (c_sol) begin
      k = 3 + int'(c_keep);
      m = (m % (1 << k)) << (8 - k);
    end
    if (c_neg) m = 255 - m;
    return m;
  endfunction

  always @(negedge clk) begin
    if (mon_en && vld_o) begin
      if (out_idx < exp_n) begin
        chk(cur_req, "y_o", int'(y_o), exp_y[out_idx]);
        chk(cur_req, "c_o", int'(c_o), exp_c[out_idx]);
        chk(cur_req, "uv_sel_o", int'(uv_o), exp_uv[out_idx]);
        chk(cur_req, "line_start_o", int'(ls_o), exp_ls[out_idx]);
        chk(cur_req, "frame_start_o", int'(fs_o), exp_fs[out_idx]);
      end
      out_idx++;
    end
  end

  task automatic run_frame(input int w, input int lines, input int seed, input bit gaps,
                           input string req);
    int n = 0;
    cur_req = req;
    for (int ln = 0; ln < lines; ln++)
      for (int x = 0; x < w; x++) begin
        int cv = (x*5 + ln*3 + seed) % 256;
        exp_y[n]  = model_y(x, ln, seed);
        exp_c[n]  = c_sep ? ((x % 2) == 1 ? 8'h14 : 8'hF0) : cv;
        exp_uv[n] = x % 2;
        exp_ls[n] = (x == 0) ? 1 : 0;
        exp_fs[n] = (x == 0 && ln == 0) ? 1 : 0;
        n++;
      end
    exp_n = n;
    out_idx = 0;
    mon_en = 1;
    for (int ln = 0; ln < lines; ln++) begin
      for (int x = 0; x < w; x++) begin
        if (gaps && (x % 5) == 2) begin
          @(posedge clk); #1;
          vld = 0; y = 8'hA5; ls = 1; fs = 1;  // idle junk must not count (R11)
        end
        @(posedge clk); #1;
        vld = 1;
        y = 8'(pix(x, ln, seed));
        c = 8'((x*5 + ln*3 + seed) % 256);
        uv = x[0];
        ls = (x == 0);
        fs = (x == 0 && ln == 0);
      end
      @(posedge clk); #1;
      vld = 0; ls = 0; fs = 0;
      @(posedge clk); #1;
    end
    repeat (4) @(posedge clk);
    #1;
    mon_en = 0;
    chk(req, "output pixel count", out_idx, exp_n);
  endtask

  task automatic clear_cfg();
    {c_mos, c_slc, c_pol, c_sol, c_neg, c_sep} = '0;
    c_size = 0; c_keep = 0; c_thr = 0;
  endtask

  task automatic t_reset();
    vld = 1; ls = 1; fs = 1; uv = 1; y = 8'h77; c = 8'h33;
    repeat (3) @(negedge clk);
    chk("R1", "vld_o in reset", int'(vld_o), 0);
    chk("R1", "y_o in reset", int'(y_o), 0);
    chk("R1", "c_o in reset", int'(c_o), 0);
    chk("R1", "markers in reset", int'({ls_o, fs_o, uv_o}), 0);
    vld = 0; ls = 0; fs = 0; uv = 0;
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk("R1", "vld_o after reset", int'(vld_o), 0);
    chk("R1", "y_o after reset", int'(y_o), 0);
  endtask

  task automatic t_latency();
    clear_cfg();
    @(posedge clk); #1;
    vld = 1; y = 8'h5A; c = 8'hC3; uv = 1; ls = 1; fs = 1;
    @(posedge clk); #1;
    vld = 0; ls = 0; fs = 0; uv = 0;
    @(negedge clk);
    chk("R2", "vld_o after 1 clk", int'(vld_o), 0);
    @(negedge clk);
    chk("R2", "vld_o after 2 clk", int'(vld_o), 1);
    chk("R2", "y_o after 2 clk", int'(y_o), 8'h5A);
    chk("R2", "c_o after 2 clk", int'(c_o), 8'hC3);
    chk("R2", "markers after 2 clk", int'({ls_o, fs_o, uv_o}), 7);
    @(negedge clk);
    chk("R2", "vld_o after 3 clk", int'(vld_o), 0);
  endtask

  task automatic t_passthrough();
    clear_cfg();
    run_frame(40, 3, 1, 1, "R2");
  endtask

  task automatic t_mosaic();
    clear_cfg();
    c_mos = 1;
    for (int s = 0; s < 4; s++) begin
      c_size = 2'(s);
      run_frame(64, 34, s + 2, s[0], s == 3 ? "R3" : "R4");
    end
    c_size = 2'd1;
    run_frame(48, 12, 7, 1, "R11");
  endtask

  task automatic t_slice();
    clear_cfg();
    c_slc = 1; c_thr = 8'h80;
    c_pol = 1; run_frame(256, 1, 0, 0, "R5");
    c_pol = 0; run_frame(256, 1, 0, 0, "R6");
    c_thr = 8'h00; c_pol = 1; run_frame(64, 2, 3, 0, "R6");
  endtask

  task automatic t_solar();
    clear_cfg();
    c_sol = 1;
    for (int k = 0; k < 4; k++) begin
      c_keep = 2'(k);
      run_frame(64, 4, k, 0, "R7");
    end
    c_slc = 1; c_thr = 8'h40; c_pol = 1;
    run_frame(64, 4, 5, 0, "R8");
  endtask

  task automatic t_negative();
    clear_cfg();
    c_neg = 1; run_frame(64, 2, 4, 0, "R9");
    c_sol = 1; c_keep = 2'd2; run_frame(64, 2, 6, 0, "R9");
    c_sol = 0; c_slc = 1; c_thr = 8'h90; c_pol = 0; run_frame(64, 2, 8, 0, "R9");
  endtask

  task automatic t_sepia();
    clear_cfg();
    c_sep = 1; run_frame(40, 2, 9, 1, "R10");
    c_neg = 1; c_mos = 1; c_size = 2'd0; run_frame(40, 8, 10, 0, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_passthrough();
    t_mosaic();
    t_slice();
    t_solar();
    t_negative();
    t_sepia();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule